// File: doc/BRIEF.md
# Serial Interface Register Front-End

This block sits between a byte-wide CPU register bus and the frame-level handshakes of a UART transmitter and receiver. It holds the receive and transmit buffers behind one shared data address, keeps the ninth data bits of 9-bit frames in a separate control register, latches receive status and error flags, and clears them through a status-read-then-data-access sequence. A combined interrupt request is raised from the error flags that software has enabled.

It also steers the serial pins. The transmit line from the shifter can be inverted in every line state, including idle and break. In single-wire half-duplex mode, a direction bit chooses whether the TxD pin drives or listens, and the receiver then hears the TxD pin. Baud timing, bit sampling and the shift registers are outside the block.

Register map (2-bit address): 0 status (read-only), 1 mode, 2 control-3, 3 data. Status bits: 0 tx-empty, 1 rx-full, 2 overrun, 3 noise, 4 framing, 5 parity. Mode bits: 0 nine-bit frames, 1 loop, 2 loop source. Control-3 bits: 0 tx ninth bit, 1 pin direction, 2 tx invert, 3 overrun enable, 4 noise enable, 5 framing enable, 6 parity enable, 7 rx ninth bit (read-only).

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x01 (only tx-empty set), mode and control-3 read 0x00, irq_o is 0 and txd_oe_o is 1.
- R2: A write to address 3 loads the transmit buffer and a read of address 3 returns the receive buffer byte; a written value is never read back there.
- R3: Tx-empty clears only on a data write that follows a status read taken while tx-empty was 1. While tx-empty is 0 and tx_ready_i is 1, tx_load_o pulses for one cycle with the buffered word, and tx-empty is 1 again in the next cycle. A data write with no such status read before it sends nothing.
- R4: With mode bit 0 set, tx_word_o[8] carries control-3 bit 0 as it was at the data write, and that bit stays in effect for later writes without being rewritten. With mode bit 0 clear, tx_word_o[8] is 0.
- R5: On rx_valid_i with rx-full clear, the byte rx_word_i[7:0] is latched, rx-full is set and the noise, framing and parity inputs set their status bits.
- R6: With mode bit 0 set, control-3 bit 7 returns the ninth received bit. A frame taken with mode bit 0 clear reads that bit as 0.
- R7: A frame arriving while rx-full is set sets overrun and leaves the buffered byte unchanged.
- R8: A data read clears exactly those of rx-full, overrun, noise, framing and parity that were set at the last status read before it. A data read with no status read before it clears nothing.
- R9: irq_o is 1 exactly when at least one of overrun, noise, framing, parity is set together with its enable bit.
- R10: With control-3 bit 2 set, txd_o is the inverse of tx_line_i in every line state; with it clear, txd_o equals tx_line_i.
- R11: With mode bits 1 and 2 both set (single-wire), txd_oe_o equals control-3 bit 1 and rx_line_o follows txd_pin_i; otherwise txd_oe_o is 1.
- R12: With mode bit 1 set and bit 2 clear, rx_line_o follows tx_line_i (internal loop); with mode bit 1 clear, it follows rxd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| rx_valid_i | input | 1 | Receiver delivers a frame |
| rx_word_i | input | 9 | Received word, bit 8 is the ninth bit |
| rx_nf_i | input | 1 | Noise seen in the frame |
| rx_fe_i | input | 1 | Framing error in the frame |
| rx_pf_i | input | 1 | Parity error in the frame |
| tx_ready_i | input | 1 | Transmit shifter can take a word |
| tx_load_o | output | 1 | Word handed to the shifter this cycle |
| tx_word_o | output | 9 | Word for the shifter |
| tx_line_i | input | 1 | Serial line level from the shifter |
| txd_o | output | 1 | TxD pin drive value |
| txd_oe_o | output | 1 | TxD pin output enable |
| txd_pin_i | input | 1 | Level sensed on the TxD pin |
| rxd_i | input | 1 | Level on the RxD pin |
| rx_line_o | output | 1 | Line chosen for the receiver |
| irq_o | output | 1 | Combined error interrupt request |

## Verification
The assertions assume the bus issues at most one access per cycle, so a status read and a data access never coincide, and that rx_valid_i is a single-cycle pulse per frame. The bench drives every access and frame as a one-cycle strobe set up on the falling edge and released on the next one, and never issues two accesses together. The transmit checks assume the shifter only sees a word when tx_load_o is high; the bench queues each expected word before the data write and matches it when that pulse appears.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;

  typedef enum logic [AW-1:0] {
    A_STAT = 2'd0,
    A_MODE = 2'd1,
    A_CTL3 = 2'd2,
    A_DATA = 2'd3
  } addr_e;

  // rx flag vector positions
  localparam int unsigned NF_FLAGS = 5;
  localparam int unsigned F_RDRF = 0;
  localparam int unsigned F_OR   = 1;
  localparam int unsigned F_NF   = 2;
  localparam int unsigned F_FE   = 3;
  localparam int unsigned F_PF   = 4;

  // control-3 bit positions
  localparam int unsigned C_T8  = 0;
  localparam int unsigned C_DIR = 1;
  localparam int unsigned C_INV = 2;
  localparam int unsigned C_ORE = 3;
  localparam int unsigned C_NFE = 4;
  localparam int unsigned C_FEE = 5;
  localparam int unsigned C_PFE = 6;
  localparam int unsigned C_R8  = 7;

  // mode bit positions
  localparam int unsigned M_WIDE = 0;
  localparam int unsigned M_LOOP = 1;
  localparam int unsigned M_RSRC = 2;
  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
  import uart_rf_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wide_i,
  input  logic                stat_rd_i,
  input  logic                data_rd_i,
  input  logic                rx_valid_i,
  input  logic [W:0]          rx_word_i,
  input  logic                rx_nf_i,
  input  logic                rx_fe_i,
  input  logic                rx_pf_i,
  output logic [W-1:0]        rx_byte_o,
  output logic                rx_ninth_o,
  output logic [NF_FLAGS-1:0] flags_o
);
  logic [NF_FLAGS-1:0] flags_q, flags_d, armed_q, armed_d;
  logic [W-1:0]        byte_q, byte_d;
  logic                ninth_q, ninth_d;

  always_comb begin
    flags_d = flags_q;
    armed_d = armed_q;
    byte_d  = byte_q;
    ninth_d = ninth_q;
    if (stat_rd_i) armed_d = flags_q;
    if (data_rd_i) begin
      flags_d = flags_q & ~armed_q;
      armed_d = '0;
    end
    if (rx_valid_i) begin
      if (flags_d[F_RDRF]) begin
        flags_d[F_OR] = 1'b1;
      end else begin
        byte_d  = rx_word_i[W-1:0];
        ninth_d = wide_i & rx_word_i[W];
        flags_d[F_RDRF] = 1'b1;
        flags_d[F_NF]   = flags_d[F_NF] | rx_nf_i;
        flags_d[F_FE]   = flags_d[F_FE] | rx_fe_i;
        flags_d[F_PF]   = flags_d[F_PF] | rx_pf_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      armed_q <= '0;
      byte_q  <= '0;
      ninth_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      armed_q <= armed_d;
      byte_q  <= byte_d;
      ninth_q <= ninth_d;
    end
  end

  assign rx_byte_o  = byte_q;
  assign rx_ninth_o = ninth_q;
  assign flags_o    = flags_q;

  // R7
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && flags_q[F_RDRF] && !data_rd_i |=> $stable(rx_byte_o) && flags_o[F_OR]);
  // R8
  rdrf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_q[F_RDRF]) |-> $past(data_rd_i));
  // R6
  narrow_ninth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !wide_i && !flags_q[F_RDRF] && !data_rd_i |=> !rx_ninth_o);
endmodule

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
  import uart_rf_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wide_i,
  input  logic         t8_i,
  input  logic         stat_rd_i,
  input  logic         data_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tx_ready_i,
  output logic         tdre_o,
  output logic         tx_load_o,
  output logic [W:0]   tx_word_o
);
  logic         tdre_q, armed_q;
  logic [W:0]   buf_q;

  assign tx_load_o = !tdre_q && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre_q  <= 1'b1;
      armed_q <= 1'b0;
      buf_q   <= '0;
    end else begin
      if (stat_rd_i && tdre_q) armed_q <= 1'b1;
      if (data_wr_i) begin
        // ninth bit captured with the byte
        buf_q <= {wide_i & t8_i, wdata_i};
        if (armed_q) begin
          tdre_q  <= 1'b0;
          armed_q <= 1'b0;
        end
      end else if (tx_load_o) begin
        tdre_q <= 1'b1;
      end
    end
  end

  assign tdre_o    = tdre_q;
  assign tx_word_o = buf_q;

  // R3
  tdre_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tdre_q) |-> $past(data_wr_i && armed_q));
  // R3
  tdre_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdre_q) |-> $past(tx_load_o));
  // R3
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o && !data_wr_i |=> !tx_load_o);
endmodule

// File: rtl/uart_rf_pin.sv
module uart_rf_pin (
  input  logic loop_i,
  input  logic rsrc_i,
  input  logic dir_i,
  input  logic inv_i,
  input  logic tx_line_i,
  input  logic txd_pin_i,
  input  logic rxd_i,
  output logic txd_o,
  output logic txd_oe_o,
  output logic rx_line_o
);
  logic single;
  assign single    = loop_i && rsrc_i;
  assign txd_o     = tx_line_i ^ inv_i;
  assign txd_oe_o  = single ? dir_i : 1'b1;
  always_comb begin
    if (!loop_i)     rx_line_o = rxd_i;
    else if (rsrc_i) rx_line_o = txd_pin_i;
    else             rx_line_o = tx_line_i;
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW:0]   rx_word_i,
  input  logic          rx_nf_i,
  input  logic          rx_fe_i,
  input  logic          rx_pf_i,
  input  logic          tx_ready_i,
  output logic          tx_load_o,
  output logic [DW:0]   tx_word_o,
  input  logic          tx_line_i,
  output logic          txd_o,
  output logic          txd_oe_o,
  input  logic          txd_pin_i,
  input  logic          rxd_i,
  output logic          rx_line_o,
  output logic          irq_o
);
  localparam int unsigned CW = DW - 1;

  logic [MODE_W-1:0]   mode_q;
  logic [CW-1:0]       ctl_q;
  logic                stat_rd, data_rd, data_wr, mode_wr, ctl_wr;
  logic [NF_FLAGS-1:0] flags;
  logic [DW-1:0]       rx_byte;
  logic                rx_ninth, tdre;

  assign stat_rd = bus_sel_i && !bus_wr_i && bus_addr_i == A_STAT;
  assign data_rd = bus_sel_i && !bus_wr_i && bus_addr_i == A_DATA;
  assign data_wr = bus_sel_i &&  bus_wr_i && bus_addr_i == A_DATA;
  assign mode_wr = bus_sel_i &&  bus_wr_i && bus_addr_i == A_MODE;
  assign ctl_wr  = bus_sel_i &&  bus_wr_i && bus_addr_i == A_CTL3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata_i[MODE_W-1:0];
      if (ctl_wr)  ctl_q  <= bus_wdata_i[CW-1:0];
    end
  end

  uart_rf_rx #(.W(DW)) i_rx (
    .clk_i, .rst_ni,
    .wide_i     (mode_q[M_WIDE]),
    .stat_rd_i  (stat_rd),
    .data_rd_i  (data_rd),
    .rx_valid_i, .rx_word_i, .rx_nf_i, .rx_fe_i, .rx_pf_i,
    .rx_byte_o  (rx_byte),
    .rx_ninth_o (rx_ninth),
    .flags_o    (flags)
  );

  uart_rf_tx #(.W(DW)) i_tx (
    .clk_i, .rst_ni,
    .wide_i    (mode_q[M_WIDE]),
    .t8_i      (ctl_q[C_T8]),
    .stat_rd_i (stat_rd),
    .data_wr_i (data_wr),
    .wdata_i   (bus_wdata_i),
    .tx_ready_i,
    .tdre_o    (tdre),
    .tx_load_o,
    .tx_word_o
  );

  uart_rf_pin i_pin (
    .loop_i (mode_q[M_LOOP]),
    .rsrc_i (mode_q[M_RSRC]),
    .dir_i  (ctl_q[C_DIR]),
    .inv_i  (ctl_q[C_INV]),
    .tx_line_i, .txd_pin_i, .rxd_i,
    .txd_o, .txd_oe_o, .rx_line_o
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_STAT: bus_rdata_o = {{(DW-NF_FLAGS-1){1'b0}}, flags, tdre};
      A_MODE: bus_rdata_o = {{(DW-MODE_W){1'b0}}, mode_q};
      A_CTL3: bus_rdata_o = {rx_ninth & mode_q[M_WIDE], ctl_q};
      A_DATA: bus_rdata_o = rx_byte;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = (flags[F_OR] & ctl_q[C_ORE]) | (flags[F_NF] & ctl_q[C_NFE])
               | (flags[F_FE] & ctl_q[C_FEE]) | (flags[F_PF] & ctl_q[C_PFE]);
endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
  logic       clk = 0, rst_ni = 0;
  logic       bus_sel_i = 0, bus_wr_i = 0;
  logic [1:0] bus_addr_i = 0;
  logic [7:0] bus_wdata_i = 0, bus_rdata_o;
  logic       rx_valid_i = 0, rx_nf_i = 0, rx_fe_i = 0, rx_pf_i = 0;
  logic [8:0] rx_word_i = 0, tx_word_o;
  logic       tx_ready_i = 1, tx_load_o, tx_line_i = 1;
  logic       txd_o, txd_oe_o, txd_pin_i = 0, rxd_i = 0, rx_line_o, irq_o;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  uart_regfront i_uart_regfront (.clk_i(clk), .*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected tx words
  always @(negedge clk) begin
    #5;
    if (rst_ni && tx_load_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3: actual load %0h expected no load", tx_word_o);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (tx_word_o !== e) begin
          errors++;
          $display("FAIL R4: actual %0h expected %0h", tx_word_o, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_sel_i = 0;
  endtask

  task automatic frame(input logic [8:0] w, input logic nf, input logic fe, input logic pf);
    @(negedge clk);
    rx_valid_i = 1; rx_word_i = w; rx_nf_i = nf; rx_fe_i = fe; rx_pf_i = pf;
    @(negedge clk);
    rx_valid_i = 0; rx_nf_i = 0; rx_fe_i = 0; rx_pf_i = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic [8:0] e);
    logic [7:0] s;
    exp_q.push_back(e);
    rd(0, s);
    wr(3, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1
    rd(0, v); check("R1 status", v, 8'h01);
    rd(1, v); check("R1 mode", v, 8'h00);
    rd(2, v); check("R1 ctl3", v, 8'h00);
    check("R1 irq", irq_o, 0);
    check("R1 oe", txd_oe_o, 1);

    // R3 R2 8-bit transmit
    send(8'hA5, 9'h0A5);
    rd(0, v); check("R3 empty again", v, 8'h01);
    // R4 nine-bit, ninth bit retained
    wr(1, 8'h01); wr(2, 8'h01);
    send(8'h3C, 9'h13C);
    send(8'h55, 9'h155);
    wr(1, 8'h00);
    send(8'h77, 9'h077);
    // R3 unarmed write sends nothing
    wr(3, 8'h99); idle(4);
    rd(0, v); check("R3 unarmed", v, 8'h01);
    // R3 shifter busy
    tx_ready_i = 0;
    exp_q.push_back(9'h011);
    wr(3, 8'h11); idle(3);
    rd(0, v); check("R3 held full", v, 8'h00);
    // R2 data read returns rx buffer, not tx
    rd(3, v); check("R2 read not tx", v, 8'h00);
    tx_ready_i = 1; idle(3);
    check("R3 queue drained", exp_q.size(), 0);

    // R5 R6 nine-bit receive
    wr(2, 8'h00); wr(1, 8'h01);
    frame(9'h1AB, 0, 0, 1);
    rd(0, v); check("R5 flags", v, 8'h23);
    rd(2, v); check("R6 ninth", v, 8'h80);
    rd(3, v); check("R2 R5 byte", v, 8'hAB);
    rd(0, v); check("R8 cleared", v, 8'h01);

    // R7 overrun
    frame(9'h012, 0, 0, 0);
    frame(9'h034, 0, 0, 0);
    rd(0, v); check("R7 overrun flag", v, 8'h07);
    rd(3, v); check("R7 byte kept", v, 8'h12);
    rd(0, v); check("R7 cleared", v, 8'h01);

    // R8 only flags seen at status read
    frame(9'h056, 0, 0, 0);
    rd(0, v); check("R8 armed", v, 8'h03);
    frame(9'h078, 0, 0, 0);
    rd(3, v); check("R8 data", v, 8'h56);
    rd(0, v); check("R8 overrun stays", v, 8'h05);
    rd(3, v);
    rd(0, v); check("R8 all clear", v, 8'h01);
    // R8 data read without status read
    frame(9'h09A, 0, 0, 0);
    rd(3, v); check("R8 byte", v, 8'h9A);
    rd(0, v); check("R8 no clear", v, 8'h03);
    rd(3, v);
    rd(0, v); check("R8 clear", v, 8'h01);

    // R9 interrupt enables
    frame(9'h0C3, 1, 0, 0);
    check("R9 disabled", irq_o, 0);
    wr(2, 8'h10); check("R9 nf enabled", irq_o, 1);
    wr(2, 8'h08); check("R9 or only", irq_o, 0);
    wr(2, 8'h10);
    rd(0, v); rd(3, v);
    check("R9 cleared", irq_o, 0);

    // R6 eight-bit receive
    wr(2, 8'h00); wr(1, 8'h00);
    frame(9'h1FF, 0, 0, 0);
    rd(0, v);
    rd(2, v); check("R6 narrow ninth", v, 8'h00);
    rd(3, v); check("R6 narrow byte", v, 8'hFF);

    // R10 inversion
    wr(2, 8'h04);
    tx_line_i = 1; #1 check("R10 idle inv", txd_o, 0);
    tx_line_i = 0; #1 check("R10 low inv", txd_o, 1);
    check("R11 oe normal", txd_oe_o, 1);
    wr(2, 8'h00);
    tx_line_i = 1; #1 check("R10 plain", txd_o, 1);

    // R11 single-wire
    wr(1, 8'h06); wr(2, 8'h04);
    rxd_i = 1; txd_pin_i = 0;
    #1 check("R11 oe input", txd_oe_o, 0);
    check("R11 rx from pin", rx_line_o, 0);
    txd_pin_i = 1; #1 check("R11 rx pin high", rx_line_o, 1);
    wr(2, 8'h06);
    check("R11 oe output", txd_oe_o, 1);
    tx_line_i = 0; #1 check("R11 drive inverted", txd_o, 1);

    // R12 internal loop and normal source
    wr(1, 8'h02);
    tx_line_i = 0; rxd_i = 1; txd_pin_i = 1;
    #1 check("R12 internal loop", rx_line_o, 0);
    wr(1, 8'h00);
    #1 check("R12 normal rxd", rx_line_o, 1);
    rxd_i = 0; #1 check("R12 normal rxd low", rx_line_o, 0);

    idle(3);
    check("R3 no stray loads", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule